// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

The block counts prescaled clock ticks in an 8-bit up-counter and reacts to the counter wrapping from 0xFF to 0x00. A free-running divider produces the count tick, and a three-bit select code chooses its rate from eight power-of-two ratios between 1/32 and 1/4096 of the input clock. Each code step doubles the time to wrap. The divider is held cleared while the timer is stopped, so the first count after a start always takes one full tick period.

One of two modes is active at a time. In watchdog mode a wrap sets a watchdog flag and raises a reset request that stays high for a fixed number of cycles. In interval mode a wrap sets a separate interval flag and gives a one-cycle interrupt pulse, and counting continues. Software reaches the block through two byte-wide registers with a single-cycle write strobe and a combinational read. One register holds the count. The other holds the run bit, the mode bit, both flags and the select code. The select code is locked while the timer runs.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the count reads 0x00 and the control register reads 0x00: stopped, interval mode, select 000, both flags clear. `irq_o` and `reset_req_o` are low.
- R2: With select code s, a count tick occurs every 2^(5+s) clock cycles (000 = 1/32 up to 111 = 1/4096). The divider is cleared while stopped, so after the start write the first tick comes 2^(5+s) cycles later.
- R3: The count advances by one per tick only while running, holds while stopped, and wraps from 0xFF to 0x00 (256 ticks per wrap). A write to address 0 loads the count and takes priority over a tick in the same cycle, and no wrap is reported in that cycle.
- R4: A write to the control register while the run bit is set leaves the select code unchanged. The run and mode bits still update. While stopped, the select code takes the written value.
- R5: The watchdog flag (control bit 5) is set only by a wrap in watchdog mode (control bit 6 = 1), never in interval mode.
- R6: The interval flag (control bit 4) is set only by a wrap in interval mode (control bit 6 = 0), never in watchdog mode.
- R7: Both flags are sticky. A control write with a 0 in a flag's bit clears it, and a 1 leaves it unchanged. A hardware set in the same cycle as a clearing write leaves the flag set.
- R8: In interval mode each wrap gives exactly one high cycle on `irq_o`, in the same cycle the flag is set, and counting continues with no gap.
- R9: In watchdog mode a wrap raises `reset_req_o` for exactly 16 consecutive cycles, starting with the cycle in which the flag is set.
- R10: Address 0 reads the count. Address 1 reads bit 7 run, bit 6 mode, bit 5 watchdog flag, bit 4 interval flag, bit 3 as 0, and bits 2:0 the select code. Writes to address 1 use the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 1 | Write address: 0 count, 1 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 count, 1 control |
| rd_data | output | 8 | Read data (combinational) |
| irq_o | output | 1 | One-cycle interval interrupt pulse |
| reset_req_o | output | 1 | Watchdog reset request, 16 cycles high |

## Verification
The hardest case to reach is a flag-clearing write that lands in the exact cycle of a wrap. The bench loads the count with 0xFF at select 000 and starts the timer. The wrap then falls exactly 32 cycles after the start write, and the bench times the clearing write to be captured at that edge. The slow select codes would need about a million cycles for a full wrap, so each code is timed from a preload of 0xFD in both modes, and one full 256-tick wrap pair is run at the fastest code.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  localparam int SEL_W  = 3;

  localparam logic ADDR_COUNT = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;

  localparam int BIT_RUN  = 7;
  localparam int BIT_MODE = 6;
  localparam int BIT_WDF  = 5;
  localparam int BIT_INTF = 4;

  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_WATCHDOG = 1'b1
  } mode_e;

  typedef struct packed {
    logic             run;
    mode_e            mode;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import timer_pkg::*;
#(
  parameter int BASE_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PRE_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    mask   = (PRE_W'(1) << (BASE_LOG2 + int'(sel_i))) - PRE_W'(1);
    tick_o = run_i && ((pre_q & mask) == mask);
    pre_d  = run_i ? pre_q + PRE_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || tick_i;
    cnt_d  = load_i ? load_val_i : cnt_q + CNT_W'(1);
    wrap_o = tick_i && !load_i && (cnt_q == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              set_wd_i,
  input  logic              set_int_i,
  output ctrl_t             ctrl_o,
  output logic              wd_flag_o,
  output logic              int_flag_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_wr;
  logic  wdf_q, wdf_d, intf_q, intf_d;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    ctrl_d  = ctrl_q;
    ctrl_d.run  = wr_data[BIT_RUN];
    ctrl_d.mode = mode_e'(wr_data[BIT_MODE]);
    if (!ctrl_q.run) ctrl_d.sel = wr_data[SEL_W-1:0];
    wdf_d  = set_wd_i  || (wdf_q  && !(ctrl_wr && !wr_data[BIT_WDF]));
    intf_d = set_int_i || (intf_q && !(ctrl_wr && !wr_data[BIT_INTF]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{run: 1'b0, mode: MODE_INTERVAL, sel: '0};
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdf_q  <= 1'b0;
      intf_q <= 1'b0;
    end else begin
      wdf_q  <= wdf_d;
      intf_q <= intf_d;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign wd_flag_o  = wdf_q;
  assign int_flag_o = intf_q;
endmodule

// File: rtl/tmr_events.sv
module tmr_events
  import timer_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wrap_i,
  input  mode_e mode_i,
  output logic  irq_o,
  output logic  req_o
);
  localparam int HW = $clog2(RST_CYCLES + 1);

  logic          irq_q, irq_d;
  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    irq_d = wrap_i && (mode_i == MODE_INTERVAL);
    if (wrap_i && (mode_i == MODE_WATCHDOG)) hold_d = HW'(RST_CYCLES);
    else if (hold_q != '0)                   hold_d = hold_q - HW'(1);
    else                                     hold_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      irq_q  <= irq_d;
      hold_q <= hold_d;
    end
  end

  assign irq_o = irq_q;
  assign req_o = (hold_q != '0);
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import timer_pkg::*;
#(
  parameter int BASE_LOG2  = 5,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o,
  output logic              reset_req_o
);
  logic             rst_n_s;
  ctrl_t            ctrl;
  logic             wd_flag, int_flag;
  logic             tick, wrap, cnt_load;
  logic             set_wd, set_int;
  logic [CNT_W-1:0] cnt;

  tmr_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  tmr_prescaler #(.BASE_LOG2(BASE_LOG2)) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run_i  (ctrl.run),
    .sel_i  (ctrl.sel),
    .tick_o (tick)
  );

  assign cnt_load = wr_en && (wr_addr == ADDR_COUNT);

  tmr_counter u_counter (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .tick_i     (tick),
    .load_i     (cnt_load),
    .load_val_i (wr_data[CNT_W-1:0]),
    .cnt_o      (cnt),
    .wrap_o     (wrap)
  );

  assign set_wd  = wrap && (ctrl.mode == MODE_WATCHDOG);
  assign set_int = wrap && (ctrl.mode == MODE_INTERVAL);

  tmr_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .set_wd_i   (set_wd),
    .set_int_i  (set_int),
    .ctrl_o     (ctrl),
    .wd_flag_o  (wd_flag),
    .int_flag_o (int_flag)
  );

  tmr_events #(.RST_CYCLES(RST_CYCLES)) u_events (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wrap_i (wrap),
    .mode_i (ctrl.mode),
    .irq_o  (irq_o),
    .req_o  (reset_req_o)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CTRL) begin
      rd_data[BIT_RUN]     = ctrl.run;
      rd_data[BIT_MODE]    = ctrl.mode;
      rd_data[BIT_WDF]     = wd_flag;
      rd_data[BIT_INTF]    = int_flag;
      rd_data[SEL_W-1:0]   = ctrl.sel;
    end else begin
      rd_data[CNT_W-1:0]   = cnt;
    end
  end
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input ctrl_t             ctrl,
  input logic              wd_flag,
  input logic              int_flag,
  input logic              irq_o,
  input logic              reset_req_o
);
  localparam int HW = $clog2(RST_CYCLES + 2);

  logic [HW-1:0] hi_cnt;
  logic          clr_wd, clr_int;

  assign clr_wd  = wr_en && (wr_addr == ADDR_CTRL) && !wr_data[BIT_WDF];
  assign clr_int = wr_en && (wr_addr == ADDR_CTRL) && !wr_data[BIT_INTF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_cnt <= '0;
    else if (reset_req_o) hi_cnt <= hi_cnt + HW'(1);
    else                  hi_cnt <= '0;
  end

  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.run |=> $stable(ctrl.sel)); // R4

  AST_WD_FLAG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_INTERVAL && !wd_flag) |=> !wd_flag); // R5

  AST_INT_FLAG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_WATCHDOG && !int_flag) |=> !int_flag); // R6

  AST_WD_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !clr_wd) |=> wd_flag); // R7

  AST_INT_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flag && !clr_int) |=> int_flag); // R7

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R8

  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> int_flag); // R8

  AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req_o) |-> wd_flag); // R9

  AST_REQ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_req_o) |-> (hi_cnt == HW'(RST_CYCLES))); // R9
endmodule

bind dual_mode_timer timer_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .ctrl        (ctrl),
  .wd_flag     (wd_flag),
  .int_flag    (int_flag),
  .irq_o       (irq_o),
  .reset_req_o (reset_req_o)
);

// File: tb/dual_mode_timer_tb.sv
`timescale 1ns/1ps
module dual_mode_timer_tb;
  logic       clk, rst_n, wr_en, wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       irq_o, reset_req_o;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  int m_run, m_mode, m_sel, m_cnt, m_pre, m_wdf, m_intf, m_irq, m_hold;

  dual_mode_timer u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .irq_o       (irq_o),
    .reset_req_o (reset_req_o)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // reference model, one step per clock
  always @(posedge clk) begin
    int  period;
    bit  tick, cwr, kwr, ovf;
    if (!rst_n) begin
      m_run = 0; m_mode = 0; m_sel = 0; m_cnt = 0; m_pre = 0;
      m_wdf = 0; m_intf = 0; m_irq = 0; m_hold = 0;
    end else begin
      period = 1 << (5 + m_sel);
      tick = (m_run != 0) && ((m_pre % period) == period - 1);
      cwr  = wr_en && (wr_addr == 1'b0);
      kwr  = wr_en && (wr_addr == 1'b1);
      ovf  = tick && (m_cnt == 255) && !cwr;
      m_irq = (ovf && m_mode == 0) ? 1 : 0;
      if (ovf && m_mode == 1) m_hold = 16;
      else if (m_hold > 0)    m_hold = m_hold - 1;
      m_wdf  = ((ovf && m_mode == 1) || (m_wdf  != 0 && !(kwr && !wr_data[5]))) ? 1 : 0;
      m_intf = ((ovf && m_mode == 0) || (m_intf != 0 && !(kwr && !wr_data[4]))) ? 1 : 0;
      m_pre  = (m_run != 0) ? (m_pre + 1) % 4096 : 0;
      if (cwr)       m_cnt = int'(wr_data);
      else if (tick) m_cnt = (m_cnt + 1) % 256;
      if (kwr) begin
        if (m_run == 0) m_sel = int'(wr_data[2:0]);
        m_run  = int'(wr_data[7]);
        m_mode = int'(wr_data[6]);
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    int exp_rd;
    if (rst_n) begin
      exp_rd = rd_addr ? ((m_run << 7) | (m_mode << 6) | (m_wdf << 5) | (m_intf << 4) | m_sel)
                       : m_cnt;
      chk(rd_addr ? "R10 model ctrl read" : "R3 model count read", int'(rd_data), exp_rd);
      chk("R8 model irq_o", int'(irq_o), m_irq);
      chk("R9 model reset_req_o", int'(reset_req_o), (m_hold != 0) ? 1 : 0);
    end
  end

  initial begin
    rd_addr = 1'b0;
    forever begin
      @(posedge clk);
      #1 rd_addr = ~rd_addr;
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk);
    #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    while (rd_addr !== a) @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, hi;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    rd(1'b1, v); chk("R1 ctrl after reset", int'(v), 8'h00);
    rd(1'b0, v); chk("R1 count after reset", int'(v), 8'h00);
    chk("R1 irq_o after reset", int'(irq_o), 0);
    chk("R1 reset_req_o after reset", int'(reset_req_o), 0);

    // R3 count holds while stopped
    wr(1'b0, 8'h5A);
    repeat (100) @(posedge clk);
    rd(1'b0, v); chk("R3 count holds when stopped", int'(v), 8'h5A);

    // R2, R6, R8: every select code in interval mode
    for (int s = 0; s < 8; s++) begin
      wr(1'b1, 8'h00);
      wr(1'b0, 8'hFD);
      wr(1'b1, 8'h80 | 8'(s));
      n = 0;
      while (n < 20000) begin
        @(posedge clk); #1; n++;
        if (irq_o) break;
      end
      chk($sformatf("R2 interval wrap time sel=%0d", s), n, 3 << (5 + s));
      @(posedge clk); #1;
      chk("R8 irq_o one cycle", int'(irq_o), 0);
      rd(1'b1, v);
      chk("R6 interval flag set", int'(v[4]), 1);
      chk("R5 watchdog flag clear in interval mode", int'(v[5]), 0);
      wr(1'b1, 8'h00);
    end

    // R2, R5, R9: every select code in watchdog mode
    for (int s = 0; s < 8; s++) begin
      wr(1'b1, 8'h00);
      wr(1'b0, 8'hFD);
      wr(1'b1, 8'hC0 | 8'(s));
      n = 0;
      while (n < 20000) begin
        @(posedge clk); #1; n++;
        if (reset_req_o) break;
      end
      chk($sformatf("R2 watchdog wrap time sel=%0d", s), n, 3 << (5 + s));
      hi = 1;
      while (hi < 40) begin
        @(posedge clk); #1;
        if (!reset_req_o) break;
        hi++;
      end
      chk("R9 reset request length", hi, 16);
      rd(1'b1, v);
      chk("R5 watchdog flag set", int'(v[5]), 1);
      chk("R6 interval flag clear in watchdog mode", int'(v[4]), 0);
      wr(1'b1, 8'h00);
    end

    // R4 select locked while running
    wr(1'b1, 8'h82);
    wr(1'b1, 8'h87);
    rd(1'b1, v);
    chk("R4 sel unchanged while running", int'(v[2:0]), 2);
    chk("R4 run still written", int'(v[7]), 1);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h05);
    rd(1'b1, v);
    chk("R4 sel accepted when stopped", int'(v[2:0]), 5);

    // R7 set wins over a clear in the same cycle
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h80);
    repeat (30) @(posedge clk);
    wr(1'b1, 8'h80);
    rd(1'b1, v);
    chk("R7 set wins over clear", int'(v[4]), 1);
    wr(1'b1, 8'h90);
    rd(1'b1, v);
    chk("R7 writing one keeps flag", int'(v[4]), 1);
    wr(1'b1, 8'h80);
    rd(1'b1, v);
    chk("R7 writing zero clears flag", int'(v[4]), 0);

    // R3, R8 full 256-tick wraps back to back
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h80);
    n = 0;
    while (n < 20000) begin
      @(posedge clk); #1; n++;
      if (irq_o) break;
    end
    chk("R3 full wrap period", n, 8192);
    n = 0;
    while (n < 20000) begin
      @(posedge clk); #1; n++;
      if (irq_o) break;
    end
    chk("R8 next wrap with no gap", n, 8192);
    wr(1'b1, 8'h00);

    repeat (5) @(posedge clk);
    summary();
    $finish;
  end
endmodule